// File: doc/BRIEF.md
# VLAN Violation Capture Unit

This block sits beside the ingress VLAN filter of a switch. When the filter finds that a frame broke the VLAN policy, it sends a one-cycle report. The report carries the ingress port number, the frame's VID and two type flags. One flag means the port is not a member of the VLAN. The other means the VID has no table entry. Both flags may be set in the same report. The block keeps the first such report and raises an interrupt. Any report that arrives while one is held is dropped.

The host services the interrupt through a small 16-bit register port. It writes a get-and-clear command to the operation register and polls that register's busy bit. When busy drops, the operation register shows the port number and the two flags, and the VID register shows the offending VID. At the moment the command completes, the interrupt is withdrawn and capture is re-armed. If a new report arrives in that exact cycle, it becomes the next pending event.

Top module: `vlan_viol_capture`

## Requirements
- R1: After reset, irq_o is low and both registers (address 0 = operation, address 1 = VID) read 16'h0000.
- R2: A report (viol_valid_i high with viol_member_i or viol_miss_i high) that arrives while nothing is pending raises irq_o in the next cycle, and irq_o stays high until a command completes.
- R3: A report with both type flags low has no effect: irq_o stays low and a later command reads back zero fields.
- R4: While an event is pending, further reports are ignored; the values read back after the next command are those of the first report.
- R5: A write to address 0 with bit 15 set and bits 14:12 equal to 3'b100 starts the get-and-clear command when the block is idle. Bit 15 of the operation register then reads 1 for exactly LAT cycles (2 by default) and returns to 0.
- R6: On completion, operation register bits 3:0 hold the source port, bit 6 holds the member flag, bit 5 holds the miss flag, and all other bits except busy read 0. VID register bits 11:0 hold the VID, and bits 15:12 read 0.
- R7: Completion deasserts irq_o and re-arms capture, so a later report is captured again.
- R8: A report with both flags set is read back with bit 6 and bit 5 both set.
- R9: A report that arrives in the completion cycle becomes the new pending event. irq_o stays high, the current readout shows the older event, and the next command returns the newer one.
- R10: A command that completes with nothing pending reads back port 0, both flags 0 and VID 0.
- R11: The following writes change neither the registers nor irq_o: writes with bit 15 clear, writes with any other opcode, writes while busy, and writes to address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| viol_valid_i | input | 1 | One-cycle violation report strobe |
| viol_port_i | input | PORT_W (4) | Ingress port of the offending frame |
| viol_vid_i | input | VID_W (12) | VID of the offending frame |
| viol_member_i | input | 1 | Port is not a member of the VLAN |
| viol_miss_i | input | 1 | VID has no table entry |
| reg_we_i | input | 1 | Host register write strobe |
| reg_addr_i | input | 1 | Register select: 0 operation, 1 VID |
| reg_wdata_i | input | 16 | Host write data |
| reg_rdata_o | output | 16 | Read data of the selected register, combinational |
| irq_o | output | 1 | Violation pending interrupt |

## Verification
A report is captured at the clock edge where it is sampled, so irq_o is checked at the falling edge that follows. A command written before a rising edge sets busy at that edge. Busy then reads 1 at the next LAT falling edges, and the readout fields and the drop of irq_o are checked at the first falling edge where busy reads 0. For the completion-cycle test, the bench counts LAT-1 falling edges after busy is first seen and asserts the new report there, so that the report is sampled at the very edge where the command completes. Every output is read half a period away from the rising edge.

// File: rtl/vvc_pkg.sv
package vvc_pkg;
  localparam int unsigned REG_W = 16;

  typedef enum logic [2:0] {
    OPC_NOP      = 3'b000,
    OPC_GETCLR   = 3'b100
  } vvc_opcode_e;

  localparam logic ADDR_OP  = 1'b0;
  localparam logic ADDR_VID = 1'b1;

  localparam int unsigned BIT_BUSY   = 15;
  localparam int unsigned BIT_MEMBER = 6;
  localparam int unsigned BIT_MISS   = 5;

  function automatic logic [REG_W-1:0] make_op_word(
    input logic       busy,
    input logic       member,
    input logic       miss,
    input logic [3:0] port
  );
    logic [REG_W-1:0] w;
    w = '0;
    w[BIT_BUSY]   = busy;
    w[BIT_MEMBER] = member;
    w[BIT_MISS]   = miss;
    w[3:0]        = port;
    return w;
  endfunction

  function automatic logic [REG_W-1:0] make_vid_word(input logic [REG_W-1:0] vid_ext);
    return vid_ext;
  endfunction

  function automatic logic is_getclr(input logic [REG_W-1:0] wdata);
    return wdata[BIT_BUSY] && (wdata[14:12] == OPC_GETCLR);
  endfunction
endpackage

// File: rtl/vvc_capture.sv
module vvc_capture #(
  parameter int unsigned PORT_W = 4,
  parameter int unsigned VID_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic [VID_W-1:0]  vid_i,
  input  logic              member_i,
  input  logic              miss_i,
  input  logic              clear_i,
  output logic              accept_o,
  output logic              pending_o,
  output logic [PORT_W-1:0] held_port_o,
  output logic [VID_W-1:0]  held_vid_o,
  output logic              held_member_o,
  output logic              held_miss_o
);
  logic is_violation;

  assign is_violation = strobe_i && (member_i || miss_i);
  assign accept_o     = is_violation && (!pending_o || clear_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_o     <= 1'b0;
      held_port_o   <= '0;
      held_vid_o    <= '0;
      held_member_o <= 1'b0;
      held_miss_o   <= 1'b0;
    end else if (accept_o) begin
      pending_o     <= 1'b1;
      held_port_o   <= port_i;
      held_vid_o    <= vid_i;
      held_member_o <= member_i;
      held_miss_o   <= miss_i;
    end else if (clear_i) begin
      pending_o     <= 1'b0;
    end
  end
endmodule

// File: rtl/vvc_cmd.sv
module vvc_cmd #(
  parameter int unsigned LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = (LAT < 2) ? 1 : $clog2(LAT);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LAT - 1);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = busy_o && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_o) begin
      if (start_i) begin
        busy_o <= 1'b1;
        cnt_q  <= CNT_LOAD;
      end
    end else if (done_o) begin
      busy_o <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/vvc_regs.sv
module vvc_regs
  import vvc_pkg::*;
#(
  parameter int unsigned PORT_W = 4,
  parameter int unsigned VID_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              pending_i,
  input  logic [PORT_W-1:0] held_port_i,
  input  logic [VID_W-1:0]  held_vid_i,
  input  logic              held_member_i,
  input  logic              held_miss_i,
  input  logic              busy_i,
  input  logic              addr_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [PORT_W-1:0] rd_port_o,
  output logic [VID_W-1:0]  rd_vid_o,
  output logic              rd_member_o,
  output logic              rd_miss_o
);
  logic [3:0]       port_ext;
  logic [REG_W-1:0] vid_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_port_o   <= '0;
      rd_vid_o    <= '0;
      rd_member_o <= 1'b0;
      rd_miss_o   <= 1'b0;
    end else if (load_i) begin
      rd_port_o   <= pending_i ? held_port_i   : '0;
      rd_vid_o    <= pending_i ? held_vid_i    : '0;
      rd_member_o <= pending_i && held_member_i;
      rd_miss_o   <= pending_i && held_miss_i;
    end
  end

  assign port_ext = 4'(rd_port_o);
  assign vid_ext  = REG_W'(rd_vid_o);

  always_comb begin
    if (addr_i == ADDR_VID) rdata_o = make_vid_word(vid_ext);
    else                    rdata_o = make_op_word(busy_i, rd_member_o, rd_miss_o, port_ext);
  end
endmodule

// File: rtl/vlan_viol_capture.sv
module vlan_viol_capture
  import vvc_pkg::*;
#(
  parameter int unsigned PORT_W = 4,
  parameter int unsigned VID_W  = 12,
  parameter int unsigned LAT    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              viol_valid_i,
  input  logic [PORT_W-1:0] viol_port_i,
  input  logic [VID_W-1:0]  viol_vid_i,
  input  logic              viol_member_i,
  input  logic              viol_miss_i,
  input  logic              reg_we_i,
  input  logic              reg_addr_i,
  input  logic [15:0]       reg_wdata_i,
  output logic [15:0]       reg_rdata_o,
  output logic              irq_o
);
  logic              cmd_start;
  logic              cmd_busy;
  logic              cmd_done;
  logic              cap_accept;
  logic              cap_pending;
  logic [PORT_W-1:0] held_port;
  logic [VID_W-1:0]  held_vid;
  logic              held_member;
  logic              held_miss;
  logic [PORT_W-1:0] rd_port;
  logic [VID_W-1:0]  rd_vid;
  logic              rd_member;
  logic              rd_miss;

  assign cmd_start = reg_we_i && (reg_addr_i == ADDR_OP) && is_getclr(reg_wdata_i) && !cmd_busy;
  assign irq_o     = cap_pending;

  vvc_capture #(.PORT_W(PORT_W), .VID_W(VID_W)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .strobe_i(viol_valid_i), .port_i(viol_port_i), .vid_i(viol_vid_i),
    .member_i(viol_member_i), .miss_i(viol_miss_i),
    .clear_i(cmd_done), .accept_o(cap_accept), .pending_o(cap_pending),
    .held_port_o(held_port), .held_vid_o(held_vid),
    .held_member_o(held_member), .held_miss_o(held_miss)
  );

  vvc_cmd #(.LAT(LAT)) u_cmd (
    .clk(clk), .rst_n(rst_n), .start_i(cmd_start),
    .busy_o(cmd_busy), .done_o(cmd_done)
  );

  vvc_regs #(.PORT_W(PORT_W), .VID_W(VID_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .load_i(cmd_done), .pending_i(cap_pending),
    .held_port_i(held_port), .held_vid_i(held_vid),
    .held_member_i(held_member), .held_miss_i(held_miss),
    .busy_i(cmd_busy), .addr_i(reg_addr_i), .rdata_o(reg_rdata_o),
    .rd_port_o(rd_port), .rd_vid_o(rd_vid),
    .rd_member_o(rd_member), .rd_miss_o(rd_miss)
  );
endmodule

// File: rtl/vvc_checker.sv
module vvc_checker #(
  parameter int unsigned PORT_W = 4,
  parameter int unsigned VID_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              viol_valid_i,
  input logic              viol_member_i,
  input logic              viol_miss_i,
  input logic              irq_o,
  input logic              cmd_start,
  input logic              cmd_busy,
  input logic              cmd_done,
  input logic [PORT_W-1:0] held_port,
  input logic [VID_W-1:0]  held_vid,
  input logic [PORT_W-1:0] rd_port,
  input logic [VID_W-1:0]  rd_vid
);
  logic report;
  assign report = viol_valid_i && (viol_member_i || viol_miss_i);

  AST_IRQ_FROM_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(report)); // R2
  AST_NOFLAG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid_i && !viol_member_i && !viol_miss_i && !irq_o) |=> !irq_o); // R3
  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !cmd_done) |=> ($stable(held_port) && $stable(held_vid))); // R4
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> cmd_busy); // R5
  AST_COPY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && irq_o) |=> (rd_port == $past(held_port) && rd_vid == $past(held_vid))); // R6
  AST_CLEAR_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && !report) |=> !irq_o); // R7
  AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && report) |=> irq_o); // R9
endmodule

bind vlan_viol_capture vvc_checker #(.PORT_W(PORT_W), .VID_W(VID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .viol_valid_i(viol_valid_i),
  .viol_member_i(viol_member_i), .viol_miss_i(viol_miss_i), .irq_o(irq_o),
  .cmd_start(cmd_start), .cmd_busy(cmd_busy), .cmd_done(cmd_done),
  .held_port(held_port), .held_vid(held_vid), .rd_port(rd_port), .rd_vid(rd_vid)
);

// File: tb/sim_vlan_viol_capture.sv
`timescale 1ns/1ps
module sim_vlan_viol_capture;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        viol_valid_i = 1'b0;
  logic [3:0]  viol_port_i = '0;
  logic [11:0] viol_vid_i = '0;
  logic        viol_member_i = 1'b0;
  logic        viol_miss_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic        reg_addr_i = 1'b0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  vlan_viol_capture #(.PORT_W(4), .VID_W(12), .LAT(LAT)) u0 (.*);

  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_op(logic bsy, logic mem, logic mis, logic [3:0] p);
    return {bsy, 8'h00, mem, mis, 1'b0, p};
  endfunction

  task automatic rd(input logic a, output logic [15:0] v);
    reg_addr_i = a;
    #1;
    v = reg_rdata_o;
  endtask

  task automatic report(input logic [3:0] p, input logic [11:0] v, input logic m, input logic s);
    viol_valid_i = 1'b1; viol_port_i = p; viol_vid_i = v;
    viol_member_i = m; viol_miss_i = s;
    @(negedge clk);
    viol_valid_i = 1'b0; viol_member_i = 1'b0; viol_miss_i = 1'b0;
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  // issue get-and-clear and count busy cycles (R5)
  task automatic getclr();
    logic [15:0] v;
    int n;
    wr(1'b0, 16'hC000);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      rd(1'b0, v);
      if (!v[15]) break;
      n++;
      @(negedge clk);
    end
    check("R5 busy cycles", 16'(n), 16'(LAT));
  endtask

  task automatic expect_out(input string tag, input logic [3:0] p, input logic [11:0] vid,
                            input logic m, input logic s);
    logic [15:0] v;
    rd(1'b0, v); check({tag, " op"}, v, exp_op(1'b0, m, s, p));
    rd(1'b1, v); check({tag, " vid"}, v, {4'h0, vid});
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R1 irq", 16'(irq_o), 16'h0);
    rd(1'b0, v); check("R1 op", v, 16'h0);
    rd(1'b1, v); check("R1 vid", v, 16'h0);
  endtask

  task automatic t_basic();
    report(4'd5, 12'h123, 1'b1, 1'b0);
    check("R2 irq raised", 16'(irq_o), 16'h1);
    repeat (3) @(negedge clk);
    check("R2 irq held", 16'(irq_o), 16'h1);
    getclr();
    expect_out("R6 member", 4'd5, 12'h123, 1'b1, 1'b0);
    check("R7 irq cleared", 16'(irq_o), 16'h0);
    report(4'd9, 12'h0A5, 1'b0, 1'b1);
    check("R7 rearmed", 16'(irq_o), 16'h1);
    getclr();
    expect_out("R6 miss", 4'd9, 12'h0A5, 1'b0, 1'b1);
  endtask

  task automatic t_both();
    report(4'd15, 12'hFFF, 1'b1, 1'b1);
    getclr();
    expect_out("R8 both", 4'd15, 12'hFFF, 1'b1, 1'b1);
  endtask

  task automatic t_noflag();
    report(4'd3, 12'h321, 1'b0, 1'b0);
    check("R3 irq", 16'(irq_o), 16'h0);
    getclr();
    expect_out("R3 fields", 4'd0, 12'h000, 1'b0, 1'b0);
  endtask

  task automatic t_ignore();
    report(4'd2, 12'h222, 1'b1, 1'b0);
    report(4'd7, 12'h777, 1'b0, 1'b1);
    @(negedge clk);
    report(4'd8, 12'h888, 1'b1, 1'b1);
    getclr();
    expect_out("R4 first kept", 4'd2, 12'h222, 1'b1, 1'b0);
    check("R4 irq", 16'(irq_o), 16'h0);
  endtask

  task automatic t_same_cycle();
    logic [15:0] v;
    report(4'd4, 12'h444, 1'b1, 1'b0);
    wr(1'b0, 16'hC000);
    rd(1'b0, v); check("R9 busy seen", 16'(v[15]), 16'h1);
    repeat (LAT - 1) @(negedge clk);
    report(4'd11, 12'hB0B, 1'b0, 1'b1);
    rd(1'b0, v); check("R9 idle", 16'(v[15]), 16'h0);
    check("R9 irq stays", 16'(irq_o), 16'h1);
    expect_out("R9 old event", 4'd4, 12'h444, 1'b1, 1'b0);
    getclr();
    expect_out("R9 new event", 4'd11, 12'hB0B, 1'b0, 1'b1);
    check("R9 irq clear", 16'(irq_o), 16'h0);
  endtask

  task automatic t_empty();
    getclr();
    expect_out("R10 empty", 4'd0, 12'h000, 1'b0, 1'b0);
  endtask

  task automatic t_badwrites();
    logic [15:0] v;
    report(4'd6, 12'h666, 1'b1, 1'b0);
    getclr();
    report(4'd1, 12'h111, 1'b0, 1'b1);
    wr(1'b0, 16'h4000);
    rd(1'b0, v); check("R11 no busy bit15 clear", v, exp_op(1'b0, 1'b1, 1'b0, 4'd6));
    wr(1'b0, 16'hB000);
    rd(1'b0, v); check("R11 other opcode", v, exp_op(1'b0, 1'b1, 1'b0, 4'd6));
    wr(1'b1, 16'hC000);
    rd(1'b1, v); check("R11 vid write", v, 16'h0666);
    check("R11 irq kept", 16'(irq_o), 16'h1);
    wr(1'b0, 16'hC000);
    wr(1'b0, 16'hC000);
    @(negedge clk);
    rd(1'b0, v); check("R11 busy write ignored", v, exp_op(1'b0, 1'b0, 1'b1, 4'd1));
    check("R11 irq after", 16'(irq_o), 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_both();
    t_noflag();
    t_ignore();
    t_same_cycle();
    t_empty();
    t_badwrites();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule